// File: doc/BRIEF.md
# Configurable Serial Audio Frame Port

This block is the digital side of a codec's serial audio link. A seven-bit control field and an eight-bit test field, both captured on a write strobe, set how it behaves. As clock master it produces the bit clock and the frame sync from the system clock. As slave it takes both from its pins through synchronizers. Each frame carries one outgoing data word, sent most significant bit first from frame bit 0, and captures one incoming word.

A frame is 64, 128 or 256 bit clocks long. The serial data pin has an active-low disable. Two loopback paths feed the receive shifter: a direct one from the outgoing serial bit, and a one-frame-delay stub that stands in for an analog path. When the data/control line falls, the block hands the bit clock and frame sync pins back to high impedance. The release happens either at once or after twelve bit clocks, and a rise of the line before that point cancels it. Settings that conflict are forced into a legal combination and latch an error flag.

Top module: `sap_frame_port`

## Requirements
- R1: Frame-length code ctrl_i[1:0] selects 00=64, 01=128 and 10=256 bit clocks per frame. As master, fsync_o is high for exactly one bit clock, at frame bit 0, so it rises every 2×N system clocks.
- R2: With the generate bit ctrl_i[4]=1, sclk_o toggles on every system clock, and the first edge after a write is a falling one. sclk_oe_o and fsync_oe_o are 1 only in master mode and are 0 after reset.
- R3: The word on tx_word_i is latched at the start of each frame. It appears on sdo_o MSB first in frame bits 0..W-1, each bit changing on a bit-clock falling edge. Frame bits W and above are 0.
- R4: sdo/sdi bits are sampled on bit-clock rising edges. After frame bit W-1 is sampled, rx_word_o holds the W bits MSB first and rx_valid_o pulses for one clock.
- R5: As slave, a high frame sync seen at a rising sclk_i edge marks frame bit 0. Transmit and receive follow the external clock.
- R6: sdo_oe_o is the inverse of the transmit-disable bit ctrl_i[6]. It is 0 after reset.
- R7: With test_i[0]=1 and test_i[1]=0, the receive shifter takes the outgoing serial bit, so rx_word_o equals the word sent in the same frame.
- R8: With test_i[0]=1 and test_i[1]=1, the receive shifter takes a stub holding the previous frame's word, so rx_word_o equals the word sent one frame earlier.
- R9: With ctrl_i[5]=1, a falling dc_i makes sclk_oe_o and fsync_oe_o 0 from the clock edge that sees the fall.
- R10: With ctrl_i[5]=0, the output enables drop at the twelfth bit-clock falling edge after the edge that sees dc_i fall.
- R11: A rise of dc_i before the release cancels the pending count, and the output enables stay 1.
- R12: Frame-length code 11 behaves as 64 bits per frame and sets cfg_err_o.
- R13: Clock-source code ctrl_i[3:2]=00 forces slave mode at 256 bits per frame. If the written frame length was not 10 or the generate bit was 1, it also sets cfg_err_o.
- R14: A nonzero write to test_i[7:2] sets cfg_err_o. cfg_err_o stays set through later legal writes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Captures ctrl_i and test_i and restarts framing |
| ctrl_i | input | 7 | [1:0] frame length, [3:2] clock source, [4] generate, [5] immediate release, [6] transmit disable |
| test_i | input | 8 | [0] loopback enable, [1] analog-stub loopback, [7:2] must be zero |
| dc_i | input | 1 | Data/control line; a fall starts the pin handoff |
| tx_word_i | input | W | Word sent in the next frame |
| sclk_i | input | 1 | External bit clock (slave) |
| fsync_i | input | 1 | External frame sync (slave) |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Generated bit clock |
| sclk_oe_o | output | 1 | Bit clock pin drive enable |
| fsync_o | output | 1 | Generated frame sync |
| fsync_oe_o | output | 1 | Frame sync pin drive enable |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data pin drive enable |
| rx_word_o | output | W | Last received word |
| rx_valid_o | output | 1 | One-clock pulse when rx_word_o updates |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
A wrong frame position shows at the pins within one frame: a fsync period that is not 2×N clocks, or a data bit on the wrong slot of sdo_o. A forced-length fault shows as a repeated MSB at bit 64 of a 256-bit slave frame. A stale or early stub shows in the next rx_word_o as the neighbouring frame's word. A handoff counter that is off by one moves the drop of the output enables by exactly one bit clock, which the bench checks on the exact edge.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int unsigned HANDOFF_DLY = 12;

  typedef struct packed {
    logic       tx_off;
    logic       rel_now;
    logic       gen;
    logic [1:0] len;
    logic       lb_en;
    logic       lb_ana;
  } sap_cfg_t;
endpackage

// File: rtl/sap_cfg.sv
module sap_cfg
  import sap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [6:0] ctrl_i,
  input  logic [7:0] test_i,
  output sap_cfg_t   cfg_o,
  output logic       err_o
);
  logic [1:0] len_raw, src_raw;
  logic       gen_raw, bad;
  sap_cfg_t   cfg_d, cfg_q;
  logic       err_q;

  always_comb begin
    len_raw = ctrl_i[1:0];
    src_raw = ctrl_i[3:2];
    gen_raw = ctrl_i[4];
    bad = (len_raw == 2'b11) || (|test_i[7:2]) ||
          ((src_raw == 2'b00) && ((len_raw != 2'b10) || gen_raw));
    cfg_d.tx_off  = ctrl_i[6];
    cfg_d.rel_now = ctrl_i[5];
    // serial clock as master clock pins the port to slave at 256 bits
    cfg_d.gen     = (src_raw == 2'b00) ? 1'b0 : gen_raw;
    cfg_d.len     = (src_raw == 2'b00) ? 2'b10 :
                    (len_raw == 2'b11) ? 2'b00 : len_raw;
    cfg_d.lb_en   = test_i[0];
    cfg_d.lb_ana  = test_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{tx_off: 1'b1, default: '0};
      err_q <= 1'b0;
    end else if (we_i) begin
      cfg_q <= cfg_d;
      err_q <= err_q | bad;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  a_r14_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r13_forced_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ctrl_i[3:2] == 2'b00) |=> (!cfg_q.gen && cfg_q.len == 2'b10));
endmodule

// File: rtl/sap_clkgen.sv
module sap_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic gen_i,
  input  logic sclk_i,
  input  logic fsync_i,
  input  logic sdi_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o,
  output logic fsync_s_o,
  output logic sdi_s_o
);
  logic       sclk_q;
  logic [2:0] sck_s;
  logic [1:0] fs_s, sd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sck_s  <= '0;
      fs_s   <= '0;
      sd_s   <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk_i};
      fs_s  <= {fs_s[0], fsync_i};
      sd_s  <= {sd_s[0], sdi_i};
      if (restart_i)  sclk_q <= 1'b1;
      else if (gen_i) sclk_q <= ~sclk_q;
    end
  end

  assign rise_o    = gen_i ? ~sclk_q : (sck_s[1] & ~sck_s[2]);
  assign fall_o    = gen_i ?  sclk_q : (~sck_s[1] & sck_s[2]);
  assign fsync_s_o = fs_s[1];
  assign sdi_s_o   = sd_s[1];
  assign sclk_o    = sclk_q;

  a_r2_master_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i && !restart_i) |=> (sclk_q != $past(sclk_q)));
endmodule

// File: rtl/sap_frame.sv
module sap_frame #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         gen_i,
  input  logic [1:0]   len_i,
  input  logic         lb_en_i,
  input  logic         lb_ana_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         fsync_s_i,
  input  logic         sdi_s_i,
  input  logic [W-1:0] tx_word_i,
  output logic         sdo_o,
  output logic         fsync_o,
  output logic [W-1:0] rx_word_o,
  output logic         rx_valid_o
);
  localparam int unsigned IW       = $clog2(W);
  localparam logic [7:0]  W_L      = 8'(W);
  localparam logic [7:0]  LAST_BIT = 8'(W - 1);

  logic [7:0]   pos_q, last, nxt, cur, tsel, rsel;
  logic [W-1:0] tx_lat_q, stub_q, rx_sh_q, rx_word_q;
  logic         sdo_q, fsync_q, rx_valid_q, tbit, rbit;

  always_comb begin
    case (len_i)
      2'b01:   last = 8'd127;
      2'b10:   last = 8'd255;
      default: last = 8'd63;
    endcase
    nxt  = (pos_q >= last) ? 8'd0 : pos_q + 8'd1;
    cur  = (!gen_i && fsync_s_i) ? 8'd0 : pos_q;
    tsel = LAST_BIT - nxt;
    rsel = LAST_BIT - cur;
    tbit = (nxt < W_L) ? tx_lat_q[tsel[IW-1:0]] : 1'b0;
    rbit = !lb_en_i ? sdi_s_i : (lb_ana_i ? stub_q[rsel[IW-1:0]] : sdo_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= 8'hFF;
      tx_lat_q   <= '0;
      stub_q     <= '0;
      rx_sh_q    <= '0;
      rx_word_q  <= '0;
      sdo_q      <= 1'b0;
      fsync_q    <= 1'b0;
      rx_valid_q <= 1'b0;
    end else if (restart_i) begin
      pos_q      <= 8'hFF;  // next falling edge opens frame bit 0
      sdo_q      <= 1'b0;
      fsync_q    <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (fall_i) begin
        pos_q   <= nxt;
        fsync_q <= gen_i && (nxt == 8'd0);
        if (nxt == 8'd0) begin
          tx_lat_q <= tx_word_i;
          stub_q   <= tx_lat_q;
          sdo_q    <= tx_word_i[W-1];
        end else begin
          sdo_q <= tbit;
        end
      end else if (rise_i) begin
        pos_q <= cur;
        if (cur < W_L) begin
          rx_sh_q <= {rx_sh_q[W-2:0], rbit};
          if (cur == LAST_BIT) begin
            rx_word_q  <= {rx_sh_q[W-2:0], rbit};
            rx_valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sdo_o      = sdo_q;
  assign fsync_o    = fsync_q;
  assign rx_word_o  = rx_word_q;
  assign rx_valid_o = rx_valid_q;

  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |=> !rx_valid_q);
  a_r1_pos_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != 8'hFF) |-> (pos_q <= last));
endmodule

// File: rtl/sap_handoff.sv
module sap_handoff
  import sap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gen_i,
  input  logic rel_now_i,
  input  logic dc_i,
  input  logic fall_i,
  output logic drive_o
);
  localparam int unsigned CW = $clog2(HANDOFF_DLY + 1);
  localparam logic [CW-1:0] DLY = CW'(HANDOFF_DLY);

  logic          dc_q, rel_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q  <= 1'b1;
      rel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      dc_q <= dc_i;
      if (dc_i) begin
        rel_q <= 1'b0;
        cnt_q <= '0;
      end else if (dc_q) begin
        if (rel_now_i) rel_q <= 1'b1;
        else           cnt_q <= DLY;
      end else if (fall_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) rel_q <= 1'b1;
      end
    end
  end

  assign drive_o = gen_i & ~rel_q;

  a_r9_release_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_q && !dc_i && rel_now_i) |=> !drive_o);
  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DLY);
  a_r11_dc_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_q |-> (!rel_q && cnt_q == '0));
endmodule

// File: rtl/sap_frame_port.sv
module sap_frame_port
  import sap_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [6:0]   ctrl_i,
  input  logic [7:0]   test_i,
  input  logic         dc_i,
  input  logic [W-1:0] tx_word_i,
  input  logic         sclk_i,
  input  logic         fsync_i,
  input  logic         sdi_i,
  output logic         sclk_o,
  output logic         sclk_oe_o,
  output logic         fsync_o,
  output logic         fsync_oe_o,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic [W-1:0] rx_word_o,
  output logic         rx_valid_o,
  output logic         cfg_err_o
);
  sap_cfg_t cfg;
  logic     rise, fall, fsync_s, sdi_s, drive;

  sap_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .ctrl_i, .test_i,
    .cfg_o(cfg), .err_o(cfg_err_o)
  );

  sap_clkgen u_clkgen (
    .clk_i, .rst_ni, .restart_i(cfg_we_i), .gen_i(cfg.gen),
    .sclk_i, .fsync_i, .sdi_i, .sclk_o,
    .rise_o(rise), .fall_o(fall), .fsync_s_o(fsync_s), .sdi_s_o(sdi_s)
  );

  sap_frame #(.W(W)) u_frame (
    .clk_i, .rst_ni, .restart_i(cfg_we_i), .gen_i(cfg.gen), .len_i(cfg.len),
    .lb_en_i(cfg.lb_en), .lb_ana_i(cfg.lb_ana), .rise_i(rise), .fall_i(fall),
    .fsync_s_i(fsync_s), .sdi_s_i(sdi_s), .tx_word_i,
    .sdo_o, .fsync_o, .rx_word_o, .rx_valid_o
  );

  sap_handoff u_handoff (
    .clk_i, .rst_ni, .gen_i(cfg.gen), .rel_now_i(cfg.rel_now),
    .dc_i, .fall_i(fall), .drive_o(drive)
  );

  assign sclk_oe_o  = drive;
  assign fsync_oe_o = drive;
  assign sdo_oe_o   = ~cfg.tx_off;

  a_r6_sdo_oe_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(cfg_we_i));
endmodule

// File: tb/sap_frame_port_bench.sv
module sap_frame_port_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  ctrl = '0;
  logic [7:0]  test = '0;
  logic        dc = 1'b1;
  logic [15:0] tx = '0;
  logic        sclk_i = 1'b0, fsync_i = 1'b0, sdi_i = 1'b0;
  logic        sclk_o, sclk_oe, fsync_o, fsync_oe, sdo, sdo_oe, rx_valid, err;
  logic [15:0] rx_word;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sap_frame_port #(.W(16)) u_sap_frame_port (
    .clk_i(clk), .rst_ni, .cfg_we_i(we), .ctrl_i(ctrl), .test_i(test), .dc_i(dc),
    .tx_word_i(tx), .sclk_i, .fsync_i, .sdi_i, .sclk_o, .sclk_oe_o(sclk_oe),
    .fsync_o, .fsync_oe_o(fsync_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid), .cfg_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input logic [1:0] len, input logic [1:0] src,
                                    input logic gen, input logic now, input logic off);
    return {off, now, gen, src, len};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] c, input logic [7:0] t);
    @(negedge clk); ctrl = c; test = t; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_fs(output int c);
    bit p;
    c = 0; p = fsync_o;
    forever begin
      @(negedge clk); c++;
      if (fsync_o && !p) break;
      p = fsync_o;
    end
  endtask

  task automatic wait_rx();
    do @(negedge clk); while (!rx_valid);
  endtask

  // master sweep at one frame length, digital loopback on
  task automatic master_check(input int n, input logic [1:0] len);
    int c;
    logic [15:0] t = 16'hB3C5;
    tx = t;
    wr(mk(len, 2'b01, 1'b1, 1'b0, 1'b0), 8'h01);
    chk("R2 master oe", {sclk_oe, fsync_oe}, 2'b11);
    chk("R6 sdo enabled", sdo_oe, 1'b1);
    wait_fs(c);
    for (int b = 0; b < n; b++) begin
      chk("R3 sdo bit", sdo, (b < 16) ? t[15-b] : 1'b0);
      chk("R1 fsync slot", fsync_o, b == 0);
      chk("R2 sclk low", sclk_o, 1'b0);
      @(negedge clk);
      chk("R2 sclk high", sclk_o, 1'b1);
      @(negedge clk);
    end
    chk("R1 fsync period", fsync_o, 1'b1);
    wait_rx();
    chk("R7 digital loopback", rx_word, t);
  endtask

  task automatic lb_seq(input logic ana);
    int c;
    logic [15:0] a = 16'h1E2D, b2 = 16'hC471;
    tx = a;
    wr(mk(2'b00, 2'b01, 1'b1, 1'b0, 1'b0), {6'b0, ana, 1'b1});
    wait_fs(c);
    tx = b2;
    wait_fs(c);
    wait_rx();
    if (ana) chk("R8 stub loopback", rx_word, a);
    else     chk("R7 same-frame loopback", rx_word, b2);
  endtask

  task automatic slave_frame(input logic [15:0] w, input int n, input bit chk_on,
                             input logic [15:0] t);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      sclk_i = 1'b0; fsync_i = (b == 0); sdi_i = (b < 16) ? w[15-b] : 1'b0;
      repeat (3) @(negedge clk);
      if (chk_on) chk("R5 slave sdo", sdo, (b < 16) ? t[15-b] : 1'b0);
      @(negedge clk);
      sclk_i = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic slave_run(input int n, input logic [6:0] c);
    logic [15:0] t = 16'hA5C3;
    tx = t;
    wr(c, 8'h00);
    slave_frame(16'h6B19, n, 1'b0, t);
    slave_frame(16'h93E4, n, 1'b1, t);
    chk("R4 slave rx word", rx_word, 16'h93E4);
    chk("R2 slave oe", {sclk_oe, fsync_oe}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, ticks;
    bit early, dropped;
    do_reset();
    chk("R2 reset oe", {sclk_oe, fsync_oe}, 2'b00);
    chk("R6 reset sdo_oe", sdo_oe, 1'b0);
    chk("R14 reset err", err, 1'b0);
    chk("R4 reset valid", rx_valid, 1'b0);

    master_check(64, 2'b00);
    master_check(128, 2'b01);
    master_check(256, 2'b10);
    chk("R14 legal keeps err clear", err, 1'b0);

    wr(mk(2'b00, 2'b01, 1'b1, 1'b0, 1'b1), 8'h00);
    chk("R6 sdo disabled", sdo_oe, 1'b0);

    lb_seq(1'b0);
    lb_seq(1'b1);

    slave_run(64, mk(2'b00, 2'b01, 1'b0, 1'b0, 1'b0));
    slave_run(128, mk(2'b01, 2'b10, 1'b0, 1'b0, 1'b0));
    slave_run(256, mk(2'b10, 2'b11, 1'b0, 1'b0, 1'b0));
    chk("R14 err still clear", err, 1'b0);

    // immediate release
    wr(mk(2'b00, 2'b01, 1'b1, 1'b1, 1'b0), 8'h00);
    @(negedge clk); dc = 1'b0;
    @(negedge clk);
    chk("R9 immediate release", {sclk_oe, fsync_oe}, 2'b00);
    dc = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 drive restored", {sclk_oe, fsync_oe}, 2'b11);

    // delayed release, exact edge
    wr(mk(2'b00, 2'b01, 1'b1, 1'b0, 1'b0), 8'h00);
    repeat (3) @(negedge clk);
    dc = 1'b0;
    @(posedge clk);
    ticks = 0; early = 1'b0;
    while (ticks < 12) begin
      logic v;
      @(negedge clk);
      if (!sclk_oe) early = 1'b1;
      v = sclk_o;
      @(posedge clk);
      if (v) ticks++;
    end
    chk("R10 no early release", early, 1'b0);
    @(negedge clk);
    chk("R10 release at 12th fall", {sclk_oe, fsync_oe}, 2'b00);
    dc = 1'b1;
    repeat (2) @(negedge clk);

    // cancel
    dc = 1'b0;
    repeat (8) @(negedge clk);
    dc = 1'b1;
    dropped = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (!sclk_oe) dropped = 1'b1;
    end
    chk("R11 cancel keeps drive", dropped, 1'b0);

    // reserved length code
    wr(mk(2'b11, 2'b01, 1'b1, 1'b0, 1'b0), 8'h00);
    chk("R12 reserved sets err", err, 1'b1);
    wait_fs(c);
    wait_fs(c);
    chk("R12 reserved as 64", c, 128);
    wr(mk(2'b01, 2'b01, 1'b1, 1'b0, 1'b0), 8'h00);
    chk("R14 err sticky", err, 1'b1);

    do_reset();
    chk("R14 err cleared by reset", err, 1'b0);
    wr(mk(2'b00, 2'b01, 1'b1, 1'b0, 1'b0), 8'h40);
    chk("R14 test upper bits", err, 1'b1);

    // serial clock as master clock with conflicting settings
    do_reset();
    slave_run(256, mk(2'b00, 2'b00, 1'b1, 1'b0, 1'b0));
    chk("R13 conflict sets err", err, 1'b1);
    do_reset();
    wr(mk(2'b10, 2'b00, 1'b0, 1'b0, 1'b0), 8'h00);
    chk("R13 legal combo no err", err, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule